// File: doc/BRIEF.md
# Gated Timestamp Tick Generator

This block makes the timestamp tick for a data-acquisition trigger system and keeps a local timestamp count. By default the tick comes from the system clock divided by four, so a 40 MHz system clock gives a 10 MHz tick. A source select can pick an external timestamp clock instead. That clock is resynchronised into the system domain, and each of its rising edges becomes one count.

A run-enable flag gates the tick. While the flag is low, no tick reaches the counter or the output pin. During that time a clear command can zero the counter, and the source select can be changed. When the flag rises at the end of the start-of-run sequence, the tick is released from a fixed phase. Every counter that follows the tick output then starts together with the local one.

The block has no streaming data path, so there is no valid/ready interface. All pins are plain level or pulse controls, sampled on every rising edge of `clk`. There is no back-pressure.

Top module: `ts_clock_gen`

## Requirements
- R1: After reset, `ts_count` is 0, `ts_tick_out` is 0, `clr_while_run_err` is 0, and the internal source is selected.
- R2: In internal mode with `run_go` high, `ts_count` rises by exactly 1 every DIV (default 4) clock edges. Counting `run_go` as sampled high first at edge 1, the first increment lands on edge DIV.
- R3: In internal mode, `ts_tick_out` is a registered square wave, high for DIV/2 clocks and low for DIV/2 clocks. With edge 1 defined as in R2, it first goes high after edge DIV-1, so it is high after edges DIV-1 and DIV.
- R4: While `run_go` is low, `ts_count` holds and `ts_tick_out` is low from the next edge on. The divider phase is cleared, so after `run_go` rises again the next increment again lands on edge DIV.
- R5: A `stamp_clr` pulse sampled while `run_go` is low sets `ts_count` to 0 on that edge.
- R6: A `stamp_clr` pulse sampled while `run_go` is high leaves counting unchanged and sets `clr_while_run_err`. Only reset clears `clr_while_run_err`.
- R7: In external mode (`src_sel_ext` = 1 latched), each rising edge of `ext_ts_clk` adds exactly 1 to `ts_count`. `ts_count` and `ts_tick_out` change on the third clock edge after the input changes, and `ts_tick_out` follows the synchronised level of `ext_ts_clk`.
- R8: `src_sel_ext` is sampled only while `run_go` is low. A change made while `run_go` is high has no effect until `run_go` has been low for at least one edge.
- R9: `ts_count` is CNT_W bits wide (default 48) and wraps from all-ones to 0 without any flag.
- R10: In external mode, rising edges of `ext_ts_clk` that occur while `run_go` is low do not change `ts_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Active-low reset, synchronous |
| run_go | input | 1 | Run enable; releases the tick when high |
| src_sel_ext | input | 1 | Source select: 0 internal divider, 1 external clock |
| ext_ts_clk | input | 1 | External timestamp clock, asynchronous |
| stamp_clr | input | 1 | Clear command for the timestamp count |
| ts_tick_out | output | 1 | Gated tick for other timestamp counters |
| ts_count | output | CNT_W | Local timestamp count |
| clr_while_run_err | output | 1 | Sticky flag: a clear arrived while running |

## Verification
The bench checks the exact edge of the first increment after `run_go` rises, and checks it again after a pause. A divider that keeps its phase across a pause, or is off by one, would move that edge. It issues a clear during a run, expecting the count to continue and the error flag to stay set. It issues a clear while idle, expecting a zero count. It changes the source select in mid-run, where a design that takes the change at once would start counting the wrong source. It sends external edges while idle, which a leaky gate would count. A narrow second instance shows the count rolling from 15 to 0.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } ts_src_e;

  localparam int unsigned TS_DIV_DFLT   = 4;
  localparam int unsigned TS_CNT_W_DFLT = 48;
  localparam int unsigned TS_SYNC_DFLT  = 2;
endpackage

// File: rtl/ts_ext_sync.sv
module ts_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic ext_level,
  output logic ext_rise
);
  logic [STAGES-1:0] shreg;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= ext_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], ext_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= shreg[STAGES-1];
  end

  assign ext_level = shreg[STAGES-1];
  assign ext_rise  = ext_level & ~last_q;

  // R7: a rising-edge strobe lasts exactly one cycle
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/ts_phase_div.sv
module ts_phase_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic int_pulse,
  output logic int_level
);
  localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)         phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                         phase_q <= phase_q + 1'b1;
  end

  assign int_pulse = run & (phase_q == PH_LAST);
  assign int_level = (phase_q >= PH_HALF);

  // R4: the phase restarts from zero after any idle cycle
  a_r4_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));

  // R2: the phase only ever steps by one or wraps to zero
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (phase_q == '0 || phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/ts_src_mux.sv
module ts_src_mux
  import ts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    sel_req,
  input  logic    int_pulse,
  input  logic    int_level,
  input  logic    ext_pulse,
  input  logic    ext_level,
  output ts_src_e sel,
  output logic    cnt_en,
  output logic    tick_q
);
  ts_src_e sel_q;
  logic    pick_pulse;
  logic    pick_level;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= SRC_INT;
    else if (!run) sel_q <= sel_req ? SRC_EXT : SRC_INT;
  end

  always_comb begin
    if (sel_q == SRC_EXT) begin
      pick_pulse = ext_pulse;
      pick_level = ext_level;
    end else begin
      pick_pulse = int_pulse;
      pick_level = int_level;
    end
  end

  assign cnt_en = run & pick_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= run & pick_level;
  end

  assign sel = sel_q;

  // R8: the selection is frozen while the run flag is high
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(sel_q));

  // R4: the output tick drops right after the run flag is low
  a_r4_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q);
endmodule

// File: rtl/ts_stamp_counter.sv
module ts_stamp_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_en,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             err
);
  logic [CNT_W-1:0] count_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            count_q <= '0;
    else if (clr && !run)  count_q <= '0;
    else if (cnt_en)       count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (clr && run) err_q <= 1'b1;
  end

  assign count = count_q;
  assign err   = err_q;

  // R4: no count change while idle without a clear
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count_q));

  // R5: an idle clear zeroes the count
  a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && clr) |=> (count_q == '0));

  // R2 / R9: while running the count steps by at most one, wrapping
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/ts_clock_gen.sv
module ts_clock_gen
  import ts_pkg::*;
#(
  parameter int unsigned CNT_W       = TS_CNT_W_DFLT,
  parameter int unsigned DIV         = TS_DIV_DFLT,
  parameter int unsigned SYNC_STAGES = TS_SYNC_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_go,
  input  logic             src_sel_ext,
  input  logic             ext_ts_clk,
  input  logic             stamp_clr,
  output logic             ts_tick_out,
  output logic [CNT_W-1:0] ts_count,
  output logic             clr_while_run_err
);
  logic    int_pulse, int_level;
  logic    ext_level, ext_rise;
  logic    cnt_en;
  ts_src_e sel;

  ts_phase_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_go),
    .int_pulse (int_pulse),
    .int_level (int_level)
  );

  ts_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_in    (ext_ts_clk),
    .ext_level (ext_level),
    .ext_rise  (ext_rise)
  );

  ts_src_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_go),
    .sel_req   (src_sel_ext),
    .int_pulse (int_pulse),
    .int_level (int_level),
    .ext_pulse (ext_rise),
    .ext_level (ext_level),
    .sel       (sel),
    .cnt_en    (cnt_en),
    .tick_q    (ts_tick_out)
  );

  ts_stamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_go),
    .cnt_en (cnt_en),
    .clr    (stamp_clr),
    .count  (ts_count),
    .err    (clr_while_run_err)
  );

  // R10: with the run flag low nothing enables the counter
  a_r10_no_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !run_go |-> !cnt_en);

  // R2: in internal mode a count step follows only a divider terminal phase
  a_r2_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_INT && cnt_en) |-> int_pulse);
endmodule

// File: tb/tb_ts_clock_gen.sv
module tb_ts_clock_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_go = 1'b0;
  logic        src_sel_ext = 1'b0;
  logic        ext_ts_clk = 1'b0;
  logic        stamp_clr = 1'b0;
  logic        ts_tick_out;
  logic [47:0] ts_count;
  logic        clr_while_run_err;
  logic        n_tick;
  logic [3:0]  n_count;
  logic        n_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ts_clock_gen dut (
    .clk(clk), .rst_n(rst_n), .run_go(run_go), .src_sel_ext(src_sel_ext),
    .ext_ts_clk(ext_ts_clk), .stamp_clr(stamp_clr), .ts_tick_out(ts_tick_out),
    .ts_count(ts_count), .clr_while_run_err(clr_while_run_err)
  );

  ts_clock_gen #(.CNT_W(4)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .run_go(run_go), .src_sel_ext(src_sel_ext),
    .ext_ts_clk(ext_ts_clk), .stamp_clr(stamp_clr), .ts_tick_out(n_tick),
    .ts_count(n_count), .clr_while_run_err(n_err)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_edge();
    ext_ts_clk = 1'b1; step(4);
    ext_ts_clk = 1'b0; step(4);
  endtask

  task automatic t_reset();
    chk("R1 count", ts_count, 0);
    chk("R1 tick", {47'd0, ts_tick_out}, 0);
    chk("R1 err", {47'd0, clr_while_run_err}, 0);
  endtask

  task automatic t_internal();
    run_go = 1'b1;
    step(3);
    chk("R2 count before first tick", ts_count, 0);
    chk("R3 tick high at edge 3", {47'd0, ts_tick_out}, 1);
    step(1);
    chk("R2 first increment edge 4", ts_count, 1);
    chk("R3 tick high at edge 4", {47'd0, ts_tick_out}, 1);
    step(1);
    chk("R3 tick low at edge 5", {47'd0, ts_tick_out}, 0);
    step(1);
    chk("R3 tick low at edge 6", {47'd0, ts_tick_out}, 0);
    step(1);
    chk("R3 tick high at edge 7", {47'd0, ts_tick_out}, 1);
    step(33);
    chk("R2 count after 40 edges", ts_count, 10);
  endtask

  task automatic t_gate();
    run_go = 1'b0;
    step(1);
    chk("R4 tick low when idle", {47'd0, ts_tick_out}, 0);
    step(10);
    chk("R4 count holds when idle", ts_count, 10);
    run_go = 1'b1;
    step(3);
    chk("R4 phase restarted, no step at edge 3", ts_count, 10);
    step(1);
    chk("R4 step at edge 4 after restart", ts_count, 11);
    run_go = 1'b0;
    step(1);
  endtask

  task automatic t_clear_run();
    run_go = 1'b1;
    stamp_clr = 1'b1;
    step(1);
    stamp_clr = 1'b0;
    step(7);
    chk("R6 clear ignored in run", ts_count, 13);
    chk("R6 error flag set", {47'd0, clr_while_run_err}, 1);
    run_go = 1'b0;
    step(1);
  endtask

  task automatic t_clear_idle();
    stamp_clr = 1'b1;
    step(1);
    stamp_clr = 1'b0;
    chk("R5 idle clear zeroes count", ts_count, 0);
    step(2);
    chk("R6 error flag sticky", {47'd0, clr_while_run_err}, 1);
  endtask

  task automatic t_external();
    src_sel_ext = 1'b1;
    step(1);
    run_go = 1'b1;
    step(8);
    chk("R8 external latched, no internal counts", ts_count, 0);
    ext_ts_clk = 1'b1;
    step(2);
    chk("R7 no step before third edge", ts_count, 0);
    chk("R7 tick still low", {47'd0, ts_tick_out}, 0);
    step(1);
    chk("R7 step on third edge", ts_count, 1);
    chk("R7 tick follows level", {47'd0, ts_tick_out}, 1);
    step(1);
    ext_ts_clk = 1'b0; step(4);
    for (int i = 0; i < 4; i++) ext_edge();
    chk("R7 one count per external edge", ts_count, 5);
  endtask

  task automatic t_ext_idle();
    run_go = 1'b0;
    step(1);
    for (int i = 0; i < 3; i++) ext_edge();
    chk("R10 idle external edges ignored", ts_count, 5);
  endtask

  task automatic t_sel_locked();
    run_go = 1'b1;
    step(1);
    src_sel_ext = 1'b0;
    step(16);
    chk("R8 mid-run select change ignored", ts_count, 5);
    ext_edge();
    ext_edge();
    chk("R8 still counting external", ts_count, 7);
    run_go = 1'b0;
    step(1);
  endtask

  task automatic t_wrap();
    stamp_clr = 1'b1;
    step(1);
    stamp_clr = 1'b0;
    run_go = 1'b1;
    step(60);
    chk("R9 narrow at 15", {44'd0, n_count}, 15);
    step(4);
    chk("R9 narrow wraps to 0", {44'd0, n_count}, 0);
    chk("R9 wide continues to 16", ts_count, 16);
    run_go = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_internal();
    t_gate();
    t_clear_run();
    t_clear_idle();
    t_external();
    t_ext_idle();
    t_sel_locked();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule